// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides an input clock by an integer ratio from 1 to 32. The high and low parts of the output are programmed separately, each as a count of input cycles. This lets the same ratio be produced with different duty cycles. A ratio of one is handled by a bypass path that sends the input clock straight to the output.

A synchronous sync input clears the divider and parks the output at a chosen starting level. Configuration is sampled only while sync is asserted. When sync is released, the output can wait a programmed number of input cycles before its pattern begins. This gives a coarse phase offset between several dividers that share one sync.

For odd ratios with a low count exactly one above the high count, an optional correction stretches the high part by half an input cycle. A flop clocked on the falling edge of the input clock does this, and the result is an exact 50% duty cycle.

Top module: `dc_clock_divider`

## Requirements
- R1: While `sync_rst` is 1, from the first rising edge at which it is sampled, `clk_out` equals `cfg_start_high` (1 = high, 0 = low), provided the sampled bypass setting is 0.
- R2: Number the rising edges after release as e0, e1, and so on, where e0 is the first edge with `sync_rst` sampled 0. The output holds the start level through edges e0 to e(P-1), where P = `cfg_delay` (0 to 15).
- R3: From edge eP on, the output repeats a pattern of D = N+M+2 input cycles, with N = `cfg_high` and M = `cfg_low`. The pattern is N+1 cycles high and M+1 cycles low. With start high, the high part comes first; with start low, the low part comes first.
- R4: A divide-by-5 can be set both as 1 high / 4 low (N=0, M=3) and as 3 high / 2 low (N=2, M=1).
- R5: Configuration inputs that change while `sync_rst` is 0 have no effect on `clk_out` until the next sync.
- R6: When the bypass setting was 1 at the last sync, `clk_out` follows `clk_in`.
- R7: With correction enabled and M = N+1, each high part lasts N+1.5 input cycles and each low part lasts N+1.5 input cycles. The extra half cycle is added to the end of the high part.
- R8: When correction is disabled, or when M differs from N+1, the output is exactly the R3 pattern.
- R9: Every (N, M) pair with N and M in the range 0 to 15 gives its R3 pattern, which covers every ratio from 2 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| sync_rst | input | 1 | Synchronous active-high reset/sync. Configuration is loaded while this is high. |
| cfg_high | input | 4 | High count N; the high part is N+1 cycles |
| cfg_low | input | 4 | Low count M; the low part is M+1 cycles |
| cfg_delay | input | 4 | Start delay after sync release, in input cycles |
| cfg_start_high | input | 1 | Starting level: 1 = high, 0 = low |
| cfg_bypass | input | 1 | 1 = pass the input clock through (divide by 1) |
| cfg_dcc_en | input | 1 | Enables the half-cycle duty correction |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions check the following on every cycle:
- The sync value forces the starting level.
- The level stays constant during the start delay.
- Level changes happen only at the two pattern boundaries.
- The falling-edge flop tracks the main level.
- The loaded configuration stays frozen outside sync.

Only the bench scenarios can show the full waveform: the exact period and split for every (N, M) pair, the half-cycle stretch measured in both clock phases, bypass pass-through, and that mid-run configuration changes do not affect the output.

// File: rtl/dc_div_pkg.sv
package dc_div_pkg;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CNT_W   = FIELD_W + 1;

  typedef struct packed {
    logic [FIELD_W-1:0] hi_cnt;
    logic [FIELD_W-1:0] lo_cnt;
    logic [FIELD_W-1:0] delay;
    logic               start_hi;
    logic               bypass;
    logic               dcc_en;
  } div_cfg_t;
endpackage

// File: rtl/dc_cfg_shadow.sv
module dc_cfg_shadow
  import dc_div_pkg::*;
(
  input  logic     clk,
  input  logic     sync_rst,
  input  div_cfg_t cfg_in,
  output div_cfg_t cfg_q
);
  // Settings are captured only during sync so a running pattern never sees a mid-period change.
  always_ff @(posedge clk) begin
    if (sync_rst) cfg_q <= cfg_in;
  end

  assert_cfg_frozen_R5: assert property (@(posedge clk) disable iff (sync_rst)
    !sync_rst |=> $stable(cfg_q));
endmodule

// File: rtl/dc_phase_seq.sv
module dc_phase_seq
  import dc_div_pkg::*;
(
  input  logic     clk,
  input  logic     sync_rst,
  input  div_cfg_t cfg_in,
  input  div_cfg_t cfg_q,
  output logic     lvl
);
  logic [FIELD_W-1:0] dly_q;
  logic [CNT_W-1:0]   pos_q;
  logic [CNT_W-1:0]   last_pos;
  logic [CNT_W-1:0]   first_len;
  logic               in_delay;

  always_comb begin
    last_pos  = CNT_W'(cfg_q.hi_cnt) + CNT_W'(cfg_q.lo_cnt) + CNT_W'(1);
    first_len = cfg_q.start_hi ? CNT_W'(cfg_q.hi_cnt) + CNT_W'(1)
                               : CNT_W'(cfg_q.lo_cnt) + CNT_W'(1);
    in_delay  = (dly_q != cfg_q.delay);
  end

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      dly_q <= '0;
      pos_q <= '0;
      lvl   <= cfg_in.start_hi;
    end else if (in_delay) begin
      dly_q <= dly_q + FIELD_W'(1);
      lvl   <= cfg_q.start_hi;
    end else begin
      lvl   <= (pos_q < first_len) ? cfg_q.start_hi : ~cfg_q.start_hi;
      pos_q <= (pos_q == last_pos) ? '0 : pos_q + CNT_W'(1);
    end
  end

  assert_sync_level_R1: assert property (@(posedge clk)
    sync_rst |=> (lvl == $past(cfg_in.start_hi)));

  assert_delay_hold_R2: assert property (@(posedge clk) disable iff (sync_rst)
    in_delay |=> $stable(lvl));

  assert_edge_at_boundary_R3: assert property (@(posedge clk) disable iff (sync_rst)
    (!in_delay && pos_q != '0 && pos_q != first_len) |=> $stable(lvl));

  assert_pos_in_range_R9: assert property (@(posedge clk) disable iff (sync_rst)
    pos_q <= last_pos);
endmodule

// File: rtl/dc_duty_fix.sv
module dc_duty_fix
  import dc_div_pkg::*;
(
  input  logic     clk,
  input  logic     sync_rst,
  input  logic     lvl,
  input  div_cfg_t cfg_q,
  output logic     clk_out
);
  logic ext_q;
  logic dcc_on;

  // Falling-edge copy of the level; OR-ing it in stretches each high part by half a cycle.
  always_ff @(negedge clk) begin
    ext_q <= lvl;
  end

  always_comb begin
    dcc_on = cfg_q.dcc_en &&
             (CNT_W'(cfg_q.lo_cnt) == CNT_W'(cfg_q.hi_cnt) + CNT_W'(1));
    if (cfg_q.bypass) clk_out = clk;
    else              clk_out = lvl | (dcc_on & ext_q);
  end

  assert_ext_tracks_R7: assert property (@(posedge clk) disable iff (sync_rst)
    ext_q == lvl);
endmodule

// File: rtl/dc_clock_divider.sv
module dc_clock_divider
  import dc_div_pkg::*;
(
  input  logic               clk_in,
  input  logic               sync_rst,
  input  logic [FIELD_W-1:0] cfg_high,
  input  logic [FIELD_W-1:0] cfg_low,
  input  logic [FIELD_W-1:0] cfg_delay,
  input  logic               cfg_start_high,
  input  logic               cfg_bypass,
  input  logic               cfg_dcc_en,
  output logic               clk_out
);
  div_cfg_t cfg_in;
  div_cfg_t cfg_q;
  logic     lvl;

  always_comb begin
    cfg_in.hi_cnt   = cfg_high;
    cfg_in.lo_cnt   = cfg_low;
    cfg_in.delay    = cfg_delay;
    cfg_in.start_hi = cfg_start_high;
    cfg_in.bypass   = cfg_bypass;
    cfg_in.dcc_en   = cfg_dcc_en;
  end

  dc_cfg_shadow u_shadow (
    .clk      (clk_in),
    .sync_rst (sync_rst),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q)
  );

  dc_phase_seq u_seq (
    .clk      (clk_in),
    .sync_rst (sync_rst),
    .cfg_in   (cfg_in),
    .cfg_q    (cfg_q),
    .lvl      (lvl)
  );

  dc_duty_fix u_fix (
    .clk      (clk_in),
    .sync_rst (sync_rst),
    .lvl      (lvl),
    .cfg_q    (cfg_q),
    .clk_out  (clk_out)
  );
endmodule

// File: tb/tb_dc_clock_divider.sv
module tb_dc_clock_divider;
  logic       clk_in = 1'b0;
  logic       sync_rst = 1'b1;
  logic [3:0] cfg_high = '0, cfg_low = '0, cfg_delay = '0;
  logic       cfg_start_high = 1'b0, cfg_bypass = 1'b0, cfg_dcc_en = 1'b0;
  logic       clk_out;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #10 clk_in = ~clk_in;

  dc_clock_divider dut (
    .clk_in(clk_in), .sync_rst(sync_rst), .cfg_high(cfg_high), .cfg_low(cfg_low),
    .cfg_delay(cfg_delay), .cfg_start_high(cfg_start_high), .cfg_bypass(cfg_bypass),
    .cfg_dcc_en(cfg_dcc_en), .clk_out(clk_out)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  function automatic logic f_at(int k, int n, int m, int p, logic sh);
    int j, first;
    if (k < p) return sh;
    j = (k - p) % (n + m + 2);
    first = sh ? n + 1 : m + 1;
    return (j < first) ? sh : ~sh;
  endfunction

  task automatic apply_sync(int n, int m, int p, logic sh, logic dcc, logic byp);
    @(negedge clk_in); #1;
    cfg_high = 4'(n); cfg_low = 4'(m); cfg_delay = 4'(p);
    cfg_start_high = sh; cfg_dcc_en = dcc; cfg_bypass = byp;
    sync_rst = 1'b1;
    @(posedge clk_in); @(posedge clk_in); #5;
    if (!byp) check(clk_out, sh, "R1", "level during sync");
    @(negedge clk_in); #1;
    sync_rst = 1'b0;
  endtask

  task automatic run_pattern(int n, int m, int p, logic sh, logic dcc, int cycles,
                             input string tag_ovr, bit scramble);
    logic  dccv, e;
    string tag;
    dccv = dcc && (m == n + 1);
    for (int k = 0; k < cycles; k++) begin
      if (tag_ovr != "")    tag = tag_ovr;
      else if (k < p)       tag = "R2";
      else if (dccv)        tag = "R7";
      else if (dcc)         tag = "R8";
      else                  tag = "R3";
      @(posedge clk_in); #5;
      e = f_at(k, n, m, p, sh) | (dccv & f_at(k - 1, n, m, p, sh));
      check(clk_out, e, tag, $sformatf("high half k=%0d N=%0d M=%0d P=%0d", k, n, m, p));
      if (scramble && k == 0) begin
        cfg_high = 4'(n + 7); cfg_low = 4'(m + 3); cfg_delay = 4'(5);
        cfg_start_high = ~sh; cfg_bypass = 1'b1; cfg_dcc_en = ~dcc;
      end
      @(negedge clk_in); #5;
      e = f_at(k, n, m, p, sh);
      check(clk_out, e, tag, $sformatf("low half k=%0d N=%0d M=%0d P=%0d", k, n, m, p));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk_in);
    #5 check(clk_out, 1'b0, "R1", "reset start-low level");

    // R9 / R3: every (N, M) pair, start high
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++) begin
        apply_sync(n, m, 0, 1'b1, 1'b0, 1'b0);
        run_pattern(n, m, 0, 1'b1, 1'b0, n + m + 5, (n == 15 || m == 15) ? "R9" : "", 0);
      end

    // R2: every start delay
    for (int p = 0; p < 16; p++) begin
      apply_sync(2, 1, p, 1'b0, 1'b0, 1'b0);
      run_pattern(2, 1, p, 1'b0, 1'b0, p + 12, "", 0);
    end

    // R3: start-low patterns
    apply_sync(3, 5, 2, 1'b0, 1'b0, 1'b0); run_pattern(3, 5, 2, 1'b0, 1'b0, 24, "R3", 0);
    apply_sync(0, 7, 0, 1'b0, 1'b0, 1'b0); run_pattern(0, 7, 0, 1'b0, 1'b0, 20, "R3", 0);

    // R4: both divide-by-5 splits
    apply_sync(0, 3, 0, 1'b1, 1'b0, 1'b0); run_pattern(0, 3, 0, 1'b1, 1'b0, 15, "R4", 0);
    apply_sync(2, 1, 0, 1'b1, 1'b0, 1'b0); run_pattern(2, 1, 0, 1'b1, 1'b0, 15, "R4", 0);

    // R5: mid-run changes ignored
    apply_sync(1, 2, 1, 1'b1, 1'b0, 1'b0); run_pattern(1, 2, 1, 1'b1, 1'b0, 20, "R5", 1);

    // R6: bypass
    apply_sync(4, 4, 0, 1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_in); #5 check(clk_out, 1'b1, "R6", "bypass high phase");
      @(negedge clk_in); #5 check(clk_out, 1'b0, "R6", "bypass low phase");
    end

    // R7: correction on every valid odd split
    for (int n = 0; n < 15; n++) begin
      apply_sync(n, n + 1, n % 3, n[0], 1'b1, 1'b0);
      run_pattern(n, n + 1, n % 3, n[0], 1'b1, 2 * (2 * n + 3) + 4, "", 0);
    end

    // R8: correction requested but not valid, or disabled
    apply_sync(2, 2, 0, 1'b1, 1'b1, 1'b0); run_pattern(2, 2, 0, 1'b1, 1'b1, 16, "R8", 0);
    apply_sync(1, 4, 0, 1'b1, 1'b1, 1'b0); run_pattern(1, 4, 0, 1'b1, 1'b1, 16, "R8", 0);
    apply_sync(2, 3, 0, 1'b1, 1'b0, 1'b0); run_pattern(2, 3, 0, 1'b1, 1'b0, 16, "R8", 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule